// File: doc/BRIEF.md
# Table-Driven Rate-1/6 Convolutional Encoder

This block turns a serial bit stream into six-bit code symbols for a decoder that expects a rate-1/6 code with constraint length 4. The encoder holds a 3-bit state (eight states). Each accepted bit produces one symbol, which is read from a fixed lookup table indexed by the current state and the input bit. No generator polynomials or XOR taps are used.

Two fixed tables are built in. The first uses eight distinct words per input value. The second repeats some words to increase the free distance. A select input picks the table once per frame, when the frame's first bit is accepted. When the bit marked as the frame's last has been accepted, the encoder stops taking input. It then shifts in three zero bits on its own, which brings the state back to zero. The symbol for the third of these bits carries an end-of-frame flag.

Bits come in on a valid/ready handshake. Symbols go out on a registered valid strobe, with no backpressure.

Top module: `conv6_encoder`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` and `outLast` are 0, and the encoder state is 000.
- R2: Each bit accepted (a cycle with `inValid` and `inReady` both 1) produces exactly one symbol. The symbol appears with `outValid` = 1 in the cycle after acceptance. Symbols keep the order of acceptance.
- R3: After every step the state becomes {bit, state[2:1]}. The new bit enters at the MSB of the state.
- R4: With table select 0, the (input 0 / input 1) words per state are as follows. The leftmost character is `outWord[5]`. State 101: 011000/010011. State 010: 110111/110000. State 000: 111000/111111. State 111: 010001/111101. State 011: 110011/100000. State 100: 011111/010010. State 001: 111110/100010. State 110: 010100/110010.
- R5: With table select 1, the (input 0 / input 1) words per state are as follows. The leftmost character is `outWord[5]`. State 110: 101010/010110. State 001: 111111/010100. State 100: 111111/100001. State 011: 001000/110100. State 000: 000011/111111. State 111: 011110/100010. State 010: 111111/001100. State 101: 001001/000110.
- R6: `tblSel` is sampled in the cycle that the first bit of a frame is accepted. That value applies to every symbol of the frame, tail included. Changes to `tblSel` at any other time have no effect.
- R7: After the bit flagged by `inLast` is accepted, the encoder emits three more symbols on three consecutive cycles, each with input bit 0. `inReady` is 0 for exactly those three cycles and returns to 1 afterwards.
- R8: `outLast` is 1 only together with the third tail symbol. The state is 000 in the cycle that `outLast` is high.
- R9: In a cycle with no acceptance and no tail step, no symbol is emitted and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| tblSel | input | 1 | Table choice (0 or 1), sampled at the start of a frame |
| inValid | input | 1 | Input bit is offered |
| inBit | input | 1 | Data bit |
| inLast | input | 1 | Marks the final data bit of the frame |
| inReady | output | 1 | Encoder can accept a bit |
| outValid | output | 1 | Symbol strobe |
| outWord | output | 6 | Code symbol |
| outLast | output | 1 | Marks the final tail symbol |

## Verification
The table latch and the first lookup of a frame happen in the same cycle. The select value captured in that cycle must already steer the first symbol. The bench changes `tblSel` at random on every cycle, including the exact cycle that accepts a frame's first bit. Every symbol is then compared against a model that froze the select value at that acceptance. A second overlap is the last tail symbol and the return of `inReady`. Frames are sent back to back, so a new first bit is offered as soon as readiness comes back. The bench checks that exactly three not-ready cycles separate the frames.

// File: rtl/enc6_pkg.sv
package enc6_pkg;
  localparam int CONSTR_LEN = 4;
  localparam int STATE_W    = CONSTR_LEN - 1;
  localparam int WORD_W     = 6;
  localparam int TAIL_LEN   = STATE_W;
  localparam int CNT_W      = $clog2(TAIL_LEN + 1);

  typedef struct packed {
    logic advance;   // shift one bit through the state this cycle
    logic zeroIn;    // shifted bit is a flush zero
    logic loadSel;   // frame start: capture table select
    logic markLast;  // this step is the final tail step
  } encStrobe_t;

  // Fixed branch-word tables; index is {table, state, input bit}.
  function automatic logic [WORD_W-1:0] branchWord(
    input logic tbl, input logic [STATE_W-1:0] st, input logic b);
    logic [WORD_W-1:0] w;
    case ({tbl, st, b})
      5'b0_000_0: w = 6'b111000;
      5'b0_000_1: w = 6'b111111;
      5'b0_001_0: w = 6'b111110;
      5'b0_001_1: w = 6'b100010;
      5'b0_010_0: w = 6'b110111;
      5'b0_010_1: w = 6'b110000;
      5'b0_011_0: w = 6'b110011;
      5'b0_011_1: w = 6'b100000;
      5'b0_100_0: w = 6'b011111;
      5'b0_100_1: w = 6'b010010;
      5'b0_101_0: w = 6'b011000;
      5'b0_101_1: w = 6'b010011;
      5'b0_110_0: w = 6'b010100;
      5'b0_110_1: w = 6'b110010;
      5'b0_111_0: w = 6'b010001;
      5'b0_111_1: w = 6'b111101;
      5'b1_000_0: w = 6'b000011;
      5'b1_000_1: w = 6'b111111;
      5'b1_001_0: w = 6'b111111;
      5'b1_001_1: w = 6'b010100;
      5'b1_010_0: w = 6'b111111;
      5'b1_010_1: w = 6'b001100;
      5'b1_011_0: w = 6'b001000;
      5'b1_011_1: w = 6'b110100;
      5'b1_100_0: w = 6'b111111;
      5'b1_100_1: w = 6'b100001;
      5'b1_101_0: w = 6'b001001;
      5'b1_101_1: w = 6'b000110;
      5'b1_110_0: w = 6'b101010;
      5'b1_110_1: w = 6'b010110;
      5'b1_111_0: w = 6'b011110;
      default:    w = 6'b100010;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/enc6_ctrl.sv
module enc6_ctrl
  import enc6_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output encStrobe_t stb
);
  typedef enum logic [1:0] {PH_IDLE, PH_BODY, PH_TAIL} phase_e;

  phase_e            phase;
  logic [CNT_W-1:0]  tailCnt;
  logic              fire;
  logic              inTail;

  always_comb begin
    inTail       = (phase == PH_TAIL);
    inReady      = !inTail;
    fire         = inValid && inReady;
    stb.advance  = fire || inTail;
    stb.zeroIn   = inTail;
    stb.loadSel  = fire && (phase == PH_IDLE);
    stb.markLast = inTail && (tailCnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tailCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE, PH_BODY: begin
          if (fire) begin
            phase   <= inLast ? PH_TAIL : PH_BODY;
            tailCnt <= CNT_W'(TAIL_LEN);
          end
        end
        default: begin
          tailCnt <= tailCnt - CNT_W'(1);
          if (tailCnt == CNT_W'(1)) phase <= PH_IDLE;
        end
      endcase
    end
  end

  // R7: the last bit closes the input for the flush
  a_r7_busy_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);
  // R7: readiness returns right after the final tail step
  a_r7_ready_after_tail: assert property (@(posedge clk) disable iff (!rstN)
    stb.markLast |=> inReady);
endmodule

// File: rtl/enc6_datapath.sv
module enc6_datapath
  import enc6_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        stb,
  input  logic              tblSel,
  input  logic              inBit,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outLast
);
  logic [STATE_W-1:0] curState;
  logic               selReg;
  logic               effSel;
  logic               effBit;
  logic [WORD_W-1:0]  nextWord;

  always_comb begin
    effSel   = stb.loadSel ? tblSel : selReg;
    effBit   = stb.zeroIn ? 1'b0 : inBit;
    nextWord = branchWord(effSel, curState, effBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= '0;
      selReg   <= 1'b0;
      outValid <= 1'b0;
      outWord  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= stb.advance;
      outLast  <= stb.advance && stb.markLast;
      if (stb.loadSel) selReg <= tblSel;
      if (stb.advance) begin
        curState <= {effBit, curState[STATE_W-1:1]};
        outWord  <= nextWord;
      end
    end
  end

  // R8: flush leaves the state at zero with the last symbol
  a_r8_flushed: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (curState == '0));
  // R9: no step, no state change
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(curState));
  // R6: table choice is frozen inside a frame
  a_r6_sel_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadSel |=> $stable(selReg));
  // R3: a zero shifted in clears the MSB
  a_r3_msb_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && stb.zeroIn) |=> !curState[STATE_W-1]);
endmodule

// File: rtl/conv6_encoder.sv
module conv6_encoder
  import enc6_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tblSel,
  input  logic       inValid,
  input  logic       inBit,
  input  logic       inLast,
  output logic       inReady,
  output logic       outValid,
  output logic [5:0] outWord,
  output logic       outLast
);
  encStrobe_t stb;

  enc6_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .stb     (stb)
  );

  enc6_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .tblSel   (tblSel),
    .inBit    (inBit),
    .outValid (outValid),
    .outWord  (outWord),
    .outLast  (outLast)
  );

  // R2: an accepted bit yields a symbol on the next cycle
  a_r2_symbol_follows: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);
  // R9: idle cycle outside the tail yields no symbol
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && inReady) |=> !outValid);
  // R8: end flag only travels with a valid symbol
  a_r8_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

// File: tb/test_conv6_encoder.sv
module test_conv6_encoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblSel = 1'b0, inValid = 1'b0, inBit = 1'b0, inLast = 1'b0;
  logic inReady, outValid, outLast;
  logic [5:0] outWord;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [5:0] tabA [16];
  logic [5:0] tabB [16];
  logic [6:0] expQ [$];
  logic [2:0] mState;
  logic       mSel;

  always #2 clk = ~clk;

  conv6_encoder i_conv6_encoder (
    .clk(clk), .rstN(rstN), .tblSel(tblSel), .inValid(inValid), .inBit(inBit),
    .inLast(inLast), .inReady(inReady), .outValid(outValid), .outWord(outWord),
    .outLast(outLast)
  );

  function automatic logic [5:0] refWord(logic sel, logic [2:0] st, logic b);
    return sel ? tabB[{st, b}] : tabA[{st, b}];
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model step: push expected symbol, advance model state
  task automatic modelStep(logic b, logic lastFlag);
    expQ.push_back({lastFlag, refWord(mSel, mState, b)});
    mState = {b, mState[2:1]};
  endtask

  // monitor: every symbol must match the head of the expected queue
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (expQ.size() == 0) begin
        check(0, "R2/R9 unexpected symbol", {10'd0, outWord}, 16'd0);
      end else begin
        logic [6:0] e;
        e = expQ.pop_front();
        check(outWord == e[5:0], "R2/R3/R4/R5/R6 word", {10'd0, outWord}, {10'd0, e[5:0]});
        check(outLast == e[6], "R8 last flag", {15'd0, outLast}, {15'd0, e[6]});
      end
    end
  end

  task automatic sendFrame(int len, int gapPct, bit fixBits, logic fixVal);
    for (int i = 0; i < len; i++) begin
      while (($urandom % 100) < gapPct) begin
        inValid = 1'b0;
        tblSel = $urandom % 2;
        @(negedge clk);
      end
      inValid = 1'b1;
      inBit = fixBits ? fixVal : logic'($urandom % 2);
      inLast = (i == len - 1);
      tblSel = $urandom % 2;
      if (i == 0) mSel = tblSel;
      check(inReady == 1'b1, "R7 ready during data", {15'd0, inReady}, 16'd1);
      modelStep(inBit, 1'b0);
      if (inLast) begin
        modelStep(1'b0, 1'b0);
        modelStep(1'b0, 1'b0);
        modelStep(1'b0, 1'b1);
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
    for (int t = 0; t < 3; t++) begin
      check(inReady == 1'b0, "R7 not ready in tail", {15'd0, inReady}, 16'd0);
      tblSel = $urandom % 2;
      @(negedge clk);
    end
    check(inReady == 1'b1, "R7 ready after tail", {15'd0, inReady}, 16'd1);
    check(mState == 3'b000, "R8 model flushed", {13'd0, mState}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] a0 [8] = '{6'b111000, 6'b111110, 6'b110111, 6'b110011,
                           6'b011111, 6'b011000, 6'b010100, 6'b010001};
    logic [5:0] a1 [8] = '{6'b111111, 6'b100010, 6'b110000, 6'b100000,
                           6'b010010, 6'b010011, 6'b110010, 6'b111101};
    logic [5:0] b0 [8] = '{6'b000011, 6'b111111, 6'b111111, 6'b001000,
                           6'b111111, 6'b001001, 6'b101010, 6'b011110};
    logic [5:0] b1 [8] = '{6'b111111, 6'b010100, 6'b001100, 6'b110100,
                           6'b100001, 6'b000110, 6'b010110, 6'b100010};
    void'($urandom(32'd4242));
    for (int s = 0; s < 8; s++) begin
      tabA[2*s] = a0[s]; tabA[2*s+1] = a1[s];
      tabB[2*s] = b0[s]; tabB[2*s+1] = b1[s];
    end
    mState = 3'b000;
    mSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(inReady == 1'b1, "R1 ready", {15'd0, inReady}, 16'd1);
    check(outValid == 1'b0, "R1 outValid", {15'd0, outValid}, 16'd0);
    check(outLast == 1'b0, "R1 outLast", {15'd0, outLast}, 16'd0);
    // directed: single-bit frames on both tables, all-ones walk, long zeros
    sendFrame(1, 0, 1, 1'b1);
    sendFrame(1, 0, 1, 1'b0);
    sendFrame(8, 0, 1, 1'b1);
    sendFrame(6, 0, 1, 1'b0);
    sendFrame(5, 60, 0, 1'b0);
    // random frames, back to back, with idle gaps
    for (int f = 0; f < 60; f++) sendFrame(1 + ($urandom % 14), $urandom % 40, 0, 1'b0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all symbols emitted", 16'(expQ.size()), 16'd0);
    check(outValid == 1'b0, "R9 quiet at end", {15'd0, outValid}, 16'd0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule